// File: doc/BRIEF.md
# Interrupt Source Coalescing State Bank

This block keeps a two-bit event state for each interrupt source in a bank. One bit (pending, P) records that the source already has a notification in the downstream queue and is waiting for end-of-interrupt. The other bit (again, Q) records that the source fired again while it was pending. Repeated triggers are merged into the Q bit, so no source ever has more than one outstanding notification.

Software works on the bank through a simple memory-mapped port. Each source owns one 4 KiB page, and the offset inside the page selects an operation. Special loads return the state as it was before the access and update it in the same cycle: end-of-interrupt, peek, or force to a chosen value. A store form of end-of-interrupt is also provided. Each new notification is placed in a round-robin arbiter and then sent out through a single valid/ready output that carries the source index.

Top module: `src_coalesce_bank`

## Requirements
- R1: Reset sets every source state to 01 (P=0, Q=1, masked), clears the notify output and leaves the read response idle.
- R2: A trigger on a source in state 00 moves it to 10 and queues one notification. ntf_valid_o rises after the second rising edge that follows the trigger cycle, provided the output is free.
- R3: A trigger on a source in state 10 moves it to 11. A trigger in state 11 leaves it at 11. Neither queues a notification.
- R4: A trigger on a source in state 01 has no effect and queues nothing.
- R5: A load at page offset 0x000 performs end-of-interrupt. 10 goes to 00. 11 goes to 10 and queues a new notification. 00 and 01 are unchanged.
- R6: A load at offset 0x800 returns the state and does not change it.
- R7: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11 respectively.
- R8: A store at offset 0x400 performs the same end-of-interrupt as R5. Stores to any other offset are ignored. No store produces a read response.
- R9: Address bit 6 (value 0x40, which marks an ordered load) is ignored when the operation is decoded.
- R10: A load to a page whose index is N_SRC or higher, or to an offset not listed in R5 to R7, returns 0xFF and changes nothing.
- R11: Every load is answered exactly one cycle later on mmio_rvalid_o. mmio_rdata_o holds the old state in bits 1 (P) and 0 (Q), and all higher bits are zero unless the answer is 0xFF.
- R12: When a trigger and an operation reach the same source in the same cycle, the load returns the state from before both. The operation is applied first and the trigger then acts on its result.
- R13: While ntf_valid_o is high and ntf_ready_i is low, the index is held stable. Sources that wait at the same time are granted in round-robin order, starting after the last source granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | N_SRC | Per-source trigger, one cycle per event |
| mmio_req_i | input | 1 | Access request |
| mmio_we_i | input | 1 | 1 = store, 0 = load |
| mmio_addr_i | input | 12+PAGE_W | Page index in the upper bits, operation offset in the low 12 bits |
| mmio_rvalid_o | output | 1 | Load answer valid |
| mmio_rdata_o | output | 64 | Load answer: old state or 0xFF |
| ntf_valid_o | output | 1 | Notification available |
| ntf_ready_i | input | 1 | Downstream accepts notification |
| ntf_idx_o | output | $clog2(N_SRC) | Index of notifying source |

## Verification
The bench aims at the collisions a simple design would get wrong. It sends a trigger and an end-of-interrupt in the same cycle: a design that applied them in the wrong order would lose the re-fire or return the new state instead of the old. It fires again while the output is stalled: a design that emits a duplicate, or drops a merged event, would show a notification with no matching fire or a fire with no notification. It checks the round-robin grant order and the index hold under backpressure, the ignored ordering bit and out-of-range pages. It also mixes in seeded random traffic.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_EOI, OP_GET, OP_SET} op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [1:0] val;
  } op_t;

  localparam op_t       OP_IDLE  = '{kind: OP_NONE, val: 2'b00};
  localparam logic [1:0] PQ_RESET = 2'b01;
  localparam logic [63:0] RD_BAD  = 64'hFF;
endpackage

// File: rtl/scb_pq_cell.sv
module scb_pq_cell
  import scb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  op_t        op_i,
  output logic [1:0] pq_o,
  output logic       fire_o
);
  logic [1:0] pq_q, pq_d;

  // operation first, then a same-cycle trigger acts on its result
  always_comb begin
    pq_d   = pq_q;
    fire_o = 1'b0;
    unique case (op_i.kind)
      OP_EOI: begin
        if (pq_q == 2'b11) begin
          pq_d   = 2'b10;
          fire_o = 1'b1;
        end else begin
          pq_d[1] = 1'b0;
        end
      end
      OP_SET:  pq_d = op_i.val;
      default: ;
    endcase
    if (trig_i) begin
      unique case (pq_d)
        2'b00: begin
          pq_d   = 2'b10;
          fire_o = 1'b1;
        end
        2'b10:   pq_d = 2'b11;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pq_q <= PQ_RESET;
    else         pq_q <= pq_d;
  end

  assign pq_o = pq_q;
endmodule

// File: rtl/scb_rr_arb.sv
module scb_rr_arb #(
  parameter int N = 12,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic          gnt_vld_o,
  output logic [IW-1:0] gnt_idx_o
);
  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_idx_o = '0;
    for (int k = 0; k < N; k++) begin
      automatic int j = int'(ptr_i) + k;
      if (j >= N) j = j - N;
      if (!gnt_vld_o && req_i[j]) begin
        gnt_vld_o = 1'b1;
        gnt_idx_o = IW'(j);
      end
    end
  end
endmodule

// File: rtl/scb_decode.sv
module scb_decode
  import scb_pkg::*;
#(
  parameter int N_SRC  = 12,
  parameter int PAGE_W = 4,
  localparam int AW    = 12 + PAGE_W
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              page_ok_o,
  output op_t               op_o,
  output logic              rd_o,
  output logic              rd_bad_o
);
  logic [11:0] off;

  assign page_o    = addr_i[AW-1:12];
  assign page_ok_o = req_i && (int'(page_o) < N_SRC);
  assign off       = addr_i[11:0] & ~12'h040;  // ordering hint is not part of the op
  assign rd_o      = req_i && !we_i;

  always_comb begin
    op_o     = OP_IDLE;
    rd_bad_o = !page_ok_o;
    if (we_i) begin
      if (off == 12'h400) op_o.kind = OP_EOI;
    end else begin
      unique case (off)
        12'h000: op_o.kind = OP_EOI;
        12'h800: op_o.kind = OP_GET;
        12'hC00: op_o = '{kind: OP_SET, val: 2'b00};
        12'hD00: op_o = '{kind: OP_SET, val: 2'b01};
        12'hE00: op_o = '{kind: OP_SET, val: 2'b10};
        12'hF00: op_o = '{kind: OP_SET, val: 2'b11};
        default: rd_bad_o = 1'b1;
      endcase
    end
    if (!page_ok_o) op_o = OP_IDLE;
  end
endmodule

// File: rtl/src_coalesce_bank.sv
module src_coalesce_bank
  import scb_pkg::*;
#(
  parameter int N_SRC  = 12,
  parameter int PAGE_W = 4,
  localparam int ADDR_W = 12 + PAGE_W,
  localparam int IDX_W  = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  trig_i,
  input  logic              mmio_req_i,
  input  logic              mmio_we_i,
  input  logic [ADDR_W-1:0] mmio_addr_i,
  output logic              mmio_rvalid_o,
  output logic [63:0]       mmio_rdata_o,
  output logic              ntf_valid_o,
  input  logic              ntf_ready_i,
  output logic [IDX_W-1:0]  ntf_idx_o
);
  logic [PAGE_W-1:0] page;
  logic              page_ok, rd_en, rd_bad;
  op_t               op;

  scb_decode #(.N_SRC(N_SRC), .PAGE_W(PAGE_W)) u_dec (
    .req_i     (mmio_req_i),
    .we_i      (mmio_we_i),
    .addr_i    (mmio_addr_i),
    .page_o    (page),
    .page_ok_o (page_ok),
    .op_o      (op),
    .rd_o      (rd_en),
    .rd_bad_o  (rd_bad)
  );

  logic [1:0]       pq [N_SRC];
  logic [N_SRC-1:0] fire, op_hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    op_t op_g;
    assign op_hit[g] = page_ok && (page == PAGE_W'(g));
    assign op_g      = op_hit[g] ? op : OP_IDLE;
    scb_pq_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trig_i (trig_i[g]),
      .op_i   (op_g),
      .pq_o   (pq[g]),
      .fire_o (fire[g])
    );
  end

  // old state of the addressed source, sampled before this cycle's update
  logic [1:0] pq_old;
  always_comb begin
    pq_old = '0;
    for (int i = 0; i < N_SRC; i++) if (op_hit[i]) pq_old = pq[i];
  end

  logic        rvalid_q;
  logic [63:0] rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_bad ? RD_BAD : {62'b0, pq_old};
    end
  end
  assign mmio_rvalid_o = rvalid_q;
  assign mmio_rdata_o  = rdata_q;

  // notify path: per-source owed flag, round-robin into one output slot
  logic [N_SRC-1:0] need_q, need_d, clr;
  logic [IDX_W-1:0] rr_ptr_q, gnt_idx, out_idx_q;
  logic             gnt_vld, out_vld_q, load_out;

  scb_rr_arb #(.N(N_SRC)) u_arb (
    .req_i     (need_q),
    .ptr_i     (rr_ptr_q),
    .gnt_vld_o (gnt_vld),
    .gnt_idx_o (gnt_idx)
  );

  assign load_out = gnt_vld && (!out_vld_q || ntf_ready_i);
  assign clr      = load_out ? (N_SRC'(1) << gnt_idx) : '0;
  assign need_d   = (need_q & ~clr) | fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      need_q    <= '0;
      rr_ptr_q  <= '0;
      out_vld_q <= 1'b0;
      out_idx_q <= '0;
    end else begin
      need_q <= need_d;
      if (load_out) begin
        out_vld_q <= 1'b1;
        out_idx_q <= gnt_idx;
        rr_ptr_q  <= (int'(gnt_idx) == N_SRC - 1) ? '0 : gnt_idx + 1'b1;
      end else if (ntf_ready_i) begin
        out_vld_q <= 1'b0;
      end
    end
  end

  assign ntf_valid_o = out_vld_q;
  assign ntf_idx_o   = out_idx_q;
endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
  parameter int N_SRC = 12,
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mmio_req_i,
  input logic             mmio_we_i,
  input logic             mmio_rvalid_o,
  input logic [63:0]      mmio_rdata_o,
  input logic             ntf_valid_o,
  input logic             ntf_ready_i,
  input logic [IDX_W-1:0] ntf_idx_o,
  input logic [1:0]       pq0_i,
  input logic             hit0_i
);
  a_r13_hold_under_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o && !ntf_ready_i |=> ntf_valid_o && $stable(ntf_idx_o));

  a_r13_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o |-> int'(ntf_idx_o) < N_SRC);

  a_r11_load_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmio_req_i && !mmio_we_i |=> mmio_rvalid_o);

  a_r8_no_spurious_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mmio_req_i && !mmio_we_i) |=> !mmio_rvalid_o);

  a_r11_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmio_rvalid_o && mmio_rdata_o != 64'hFF |-> mmio_rdata_o[63:2] == '0);

  a_r4_masked_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pq0_i == 2'b01 && !hit0_i |=> pq0_i == 2'b01);

  a_r3_pending_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pq0_i[1] && !hit0_i |=> pq0_i[1]);
endmodule

bind src_coalesce_bank scb_checker #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mmio_req_i    (mmio_req_i),
  .mmio_we_i     (mmio_we_i),
  .mmio_rvalid_o (mmio_rvalid_o),
  .mmio_rdata_o  (mmio_rdata_o),
  .ntf_valid_o   (ntf_valid_o),
  .ntf_ready_i   (ntf_ready_i),
  .ntf_idx_o     (ntf_idx_o),
  .pq0_i         (pq[0]),
  .hit0_i        (op_hit[0])
);

// File: tb/src_coalesce_bank_bench.sv
`timescale 1ns/1ps
module src_coalesce_bank_bench;
  localparam int N  = 12;
  localparam int PW = 4;
  localparam int AW = 12 + PW;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  trig = '0;
  logic          req = 1'b0, we = 1'b0, rdy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rvalid, nvalid;
  logic [63:0]   rdata;
  logic [IW-1:0] nidx;

  always #2.5 clk = ~clk;

  src_coalesce_bank #(.N_SRC(N), .PAGE_W(PW)) u_src_coalesce_bank (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
    .mmio_req_i(req), .mmio_we_i(we), .mmio_addr_i(addr),
    .mmio_rvalid_o(rvalid), .mmio_rdata_o(rdata),
    .ntf_valid_o(nvalid), .ntf_ready_i(rdy), .ntf_idx_o(nidx)
  );

  int checks = 0, errors = 0;
  logic [1:0]  pq_m [N];
  int          exp_cnt [N], got_cnt [N];
  bit          exp_rv = 0;
  logic [63:0] exp_rd = '0;
  bit          prev_stall = 0;
  logic [IW-1:0] prev_idx = '0;
  int          log_idx [8];
  int          log_n = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [1:0] eoi_f(logic [1:0] s, output bit f);
    f = (s == 2'b11);
    return (s == 2'b11) ? 2'b10 : {1'b0, s[0]};
  endfunction

  function automatic logic [1:0] trig_f(logic [1:0] s, output bit f);
    f = (s == 2'b00);
    return (s == 2'b00) ? 2'b10 : (s == 2'b10) ? 2'b11 : s;
  endfunction

  // one cycle: check previous answer and notify, then drive and update the model
  task automatic step(logic [N-1:0] t, bit rq, bit w, int pg, logic [11:0] off, bit r);
    @(negedge clk);
    chk("R11 rvalid", {63'b0, rvalid}, {63'b0, exp_rv});
    if (exp_rv) chk("R11 rdata", rdata, exp_rd);
    if (prev_stall) begin
      chk("R13 hold valid", {63'b0, nvalid}, 64'd1);
      chk("R13 hold idx", 64'(nidx), 64'(prev_idx));
    end
    rdy = r;
    if (nvalid && r) begin
      if (got_cnt[nidx] >= exp_cnt[nidx]) begin
        errors++; checks++;
        $display("FAIL R2 notify without fire src=%0d actual=%0d expected<%0d", nidx, got_cnt[nidx], exp_cnt[nidx]);
      end
      got_cnt[nidx]++;
      if (log_n < 8) begin log_idx[log_n] = nidx; log_n++; end
    end
    prev_stall = nvalid && !r;
    prev_idx   = nidx;
    trig = t; req = rq; we = w; addr = {PW'(pg), off};
    exp_rv = rq && !w;
    exp_rd = 64'hFF;
    if (rq && pg < N) begin
      logic [1:0] o;
      logic [11:0] k;
      bit f;
      o = pq_m[pg];
      k = off & ~12'h040;
      if (!w) begin
        case (k)
          12'h000: begin exp_rd = 64'(o); pq_m[pg] = eoi_f(o, f); if (f) exp_cnt[pg]++; end
          12'h800: exp_rd = 64'(o);
          12'hC00: begin exp_rd = 64'(o); pq_m[pg] = 2'b00; end
          12'hD00: begin exp_rd = 64'(o); pq_m[pg] = 2'b01; end
          12'hE00: begin exp_rd = 64'(o); pq_m[pg] = 2'b10; end
          12'hF00: begin exp_rd = 64'(o); pq_m[pg] = 2'b11; end
          default: ;
        endcase
      end else if (k == 12'h400) begin
        pq_m[pg] = eoi_f(o, f);
        if (f) exp_cnt[pg]++;
      end
    end
    for (int i = 0; i < N; i++) if (t[i]) begin
      bit f;
      pq_m[i] = trig_f(pq_m[i], f);
      if (f) exp_cnt[i]++;
    end
  endtask

  task automatic idle(int n, bit r);
    for (int i = 0; i < n; i++) step('0, 0, 0, 0, 12'h0, r);
  endtask

  task automatic ld(int pg, logic [11:0] off);
    step('0, 1, 0, pg, off, 0);
  endtask

  bit done = 0;
  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] offs [10] = '{12'h000, 12'h800, 12'h400, 12'hC00, 12'hD00,
                               12'hE00, 12'hF00, 12'h040, 12'h840, 12'h123};
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin pq_m[i] = 2'b01; exp_cnt[i] = 0; got_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 notify idle", {63'b0, nvalid}, 64'd0);
    chk("R1 read idle", {63'b0, rvalid}, 64'd0);
    rst_n = 1'b1;
    // R1 / R6 / R10: peek every page, out-of-range pages give 0xFF
    for (int p = 0; p < (1 << PW); p++) ld(p, 12'h800);
    ld(0, 12'h100);                       // R10 bad offset
    ld(0, 12'h800);
    // R4 masked trigger
    step(N'(1) << 3, 0, 0, 0, 0, 0);
    idle(3, 0);
    chk("R4 no notify", {63'b0, nvalid}, 64'd0);
    ld(3, 12'h800);
    // R9 ordered set, R7 all set values on source 7
    ld(0, 12'hC40);
    ld(1, 12'hC00); ld(2, 12'hC00);
    ld(7, 12'hD00); ld(7, 12'hE00); ld(7, 12'hF00); ld(7, 12'hC00); ld(7, 12'hD00);
    // R2 latency and R13 round-robin order
    step(N'(7), 0, 0, 0, 0, 0);
    step('0, 0, 0, 0, 0, 0);
    chk("R2 latency low", {63'b0, nvalid}, 64'd0);
    step('0, 0, 0, 0, 0, 0);
    chk("R2 latency high", {63'b0, nvalid}, 64'd1);
    chk("R13 first idx", 64'(nidx), 64'd0);
    idle(3, 0);
    idle(6, 1);
    chk("R13 grant count", 64'(log_n), 64'd3);
    for (int i = 0; i < 3; i++) chk("R13 rr order", 64'(log_idx[i]), 64'(i));
    // R3 coalescing: two more triggers on pending source 0
    step(N'(1), 0, 0, 0, 0, 1);
    step(N'(1), 0, 0, 0, 0, 1);
    idle(3, 1);
    chk("R3 no extra notify", {63'b0, nvalid}, 64'd0);
    ld(0, 12'h800);
    // R5 load eoi from 11 re-fires, R8 store eoi and ignored store
    ld(0, 12'h000);
    step('0, 1, 1, 1, 12'h400, 0);
    step('0, 1, 1, 2, 12'h800, 0);
    ld(1, 12'h800); ld(2, 12'h800); ld(0, 12'h800);
    // R12 same-cycle eoi and trigger on source 5
    ld(5, 12'hE00);
    step(N'(1) << 5, 1, 0, 5, 12'h000, 0);
    ld(5, 12'h800);
    idle(20, 1);
    // random mix
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] t;
      for (int i = 0; i < N; i++) t[i] = ($urandom % 8) == 0;
      step(t, ($urandom % 2) == 0, ($urandom % 4) == 0, $urandom % (1 << PW),
           offs[$urandom % 10], ($urandom % 3) != 0);
    end
    idle(4 * N, 1);
    for (int i = 0; i < N; i++) begin
      chk("R2 fired source notified", 64'(got_cnt[i] > 0), 64'(exp_cnt[i] > 0));
      chk("R3 notify bound", 64'(got_cnt[i] <= exp_cnt[i]), 64'd1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule